// File: doc/BRIEF.md
# Multiplication-free clamping neuron datapath

This block produces the forward output of one neuron without using a multiplier. Each synapse has two parameters, a channel width and a leak level. An input element goes through two parallel paths. In each path the magnitude of the element is limited to the magnitude of that path's parameter, and the element's original sign is then put back. The neuron adds both path results for every element to a single bias. It divides the total by the square root of the vector length with one static arithmetic right shift.

Elements arrive one per cycle, qualified by `in_valid`, and `in_last` marks the final element. The bias is taken with the first element of each vector. The result is registered and appears with a one-cycle `out_valid` pulse on the cycle after the last element. A new vector may begin on the following cycle. `DEPTH` must be a power of four, and the shift is log2(DEPTH)/2.

Top module: `clamp_neuron`

## Requirements
- R1: For each accepted element, the channel term equals sign(x)·min(|x|,|w|) and is added to the sum.
- R2: For each accepted element, the leak term equals sign(x)·min(|x|,|n|) and is added to the sum.
- R3: The bias is added once per vector. It is taken from `in_bias` on the first accepted element after reset or after a last element, and `in_bias` is ignored on every later element of that vector.
- R4: `out_y` equals the full sum shifted right arithmetically by log2(DEPTH)/2. This rounds toward minus infinity, so a sum of -1 gives -1.
- R5: Inputs and parameters are two's-complement. The magnitude of the most negative value (-2^(DATA_W-1)) is taken as 2^(DATA_W-1)-1.
- R6: An element with x = 0 contributes zero in both paths, whatever the values of w and n.
- R7: The accumulator is DATA_W+ceil(log2(2·DEPTH+1)) bits wide. A full-length vector of extreme values therefore gives the exact result, with no overflow.
- R8: `out_valid` is high for exactly one cycle, in the cycle after an accepted element that has `in_last` high, and is low at every other time, including after reset.
- R9: Vectors may follow back to back, with no idle cycle between them. Each vector's sum starts again from its own bias.
- R10: `out_y` resets to 0 and changes only when `out_valid` is high.
- R11: Cycles with `in_valid` low have no effect on the sum, whatever is on the data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element valid |
| in_last | input | 1 | Final element of the vector |
| in_x | input | DATA_W | Signed input element |
| in_w | input | DATA_W | Signed channel-width parameter |
| in_n | input | DATA_W | Signed leak-level parameter |
| in_bias | input | DATA_W | Signed bias, taken on the first element |
| out_valid | output | 1 | Result strobe |
| out_y | output | DATA_W+ceil(log2(2·DEPTH+1)) | Signed shifted sum |

## Verification
The hardest case to reach is a vector that ends on one cycle while the next one starts on the following cycle. That case needs the sum to restart from the new bias in the same cycle that the previous result is registered. Other tests have idle gaps and junk data inside a vector, so the restart must not depend on quiet cycles. The stimulus reaches both cases by mixing seeded random vectors of random lengths, sent both back to back and with gaps. It adds directed vectors that use the most negative code, zero inputs and full-length extremes, which drive the saturation and width limits.

// File: rtl/clamp_neuron.sv
module clamp_neuron #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_last,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic signed [DATA_W-1:0] in_w,
  input  logic signed [DATA_W-1:0] in_n,
  input  logic signed [DATA_W-1:0] in_bias,
  output logic                    out_valid,
  output logic signed [DATA_W+$clog2(2*DEPTH+1)-1:0] out_y
);
  localparam int SHIFT = $clog2(DEPTH) / 2;
  localparam int ACC_W = DATA_W + $clog2(2*DEPTH+1);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_MAG  = {1'b0, {(DATA_W-1){1'b1}}};

  function automatic logic [DATA_W-1:0] mag(input logic [DATA_W-1:0] v);
    if (v == MOST_NEG) return MAX_MAG;
    return v[DATA_W-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic signed [ACC_W-1:0] clamp(input logic [DATA_W-1:0] x,
                                                    input logic [DATA_W-1:0] p);
    logic [DATA_W-1:0] mx, mp, m;
    logic signed [ACC_W-1:0] e;
    mx = mag(x);
    mp = mag(p);
    m  = (mx < mp) ? mx : mp;
    e  = $signed({{(ACC_W-DATA_W){1'b0}}, m});
    return x[DATA_W-1] ? -e : e;
  endfunction

  logic                    first_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] bias_ext, chan_t, leak_t, acc_next;

  assign bias_ext = {{(ACC_W-DATA_W){in_bias[DATA_W-1]}}, in_bias};
  assign chan_t   = clamp(in_x, in_w);
  assign leak_t   = clamp(in_x, in_n);
  assign acc_next = (first_q ? bias_ext : acc_q) + chan_t + leak_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q   <= 1'b1;
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= in_valid && in_last;
      if (in_valid) begin
        acc_q   <= acc_next;
        first_q <= in_last;
        if (in_last) out_y <= acc_next >>> SHIFT;
      end
    end
  end
endmodule

// File: rtl/clamp_neuron_chk.sv
module clamp_neuron_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_last,
  input logic signed [DATA_W-1:0] in_x,
  input logic signed [DATA_W-1:0] in_bias,
  input logic                    first_q,
  input logic                    out_valid,
  input logic signed [DATA_W+$clog2(2*DEPTH+1)-1:0] out_y
);
  localparam int SHIFT = $clog2(DEPTH) / 2;
  localparam int BOUND = ((2*DEPTH*((1 << (DATA_W-1)) - 1) + (1 << (DATA_W-1))) >> SHIFT) + 1;

  p_valid_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> out_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> $stable(out_y));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_y) <= BOUND && int'(out_y) >= -BOUND));
  p_zero_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && first_q && in_x == '0 && in_bias == '0) |=> out_y == '0);
endmodule

bind clamp_neuron clamp_neuron_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .in_x(in_x), .in_bias(in_bias), .first_q(first_q),
  .out_valid(out_valid), .out_y(out_y));

// File: tb/clamp_neuron_tb.sv
module clamp_neuron_tb;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int SHIFT  = 2;
  localparam int ACC_W  = DATA_W + $clog2(2*DEPTH+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic signed [DATA_W-1:0] in_x = '0, in_w = '0, in_n = '0, in_bias = '0;
  logic out_valid;
  logic signed [ACC_W-1:0] out_y;

  always #4 clk = ~clk;

  clamp_neuron #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_x(in_x), .in_w(in_w), .in_n(in_n), .in_bias(in_bias),
    .out_valid(out_valid), .out_y(out_y));

  int errors = 0, checks = 0;
  int vx[DEPTH], vw[DEPTH], vn[DEPTH], vb[DEPTH];
  int exp_q[$];
  string tag_q[$];
  int last_y = 0;
  bit done = 0;

  function automatic int magm(int v);
    if (v == -128) return 127;
    return v < 0 ? -v : v;
  endfunction

  function automatic int clampm(int x, int p);
    int m;
    m = (magm(x) < magm(p)) ? magm(x) : magm(p);
    return x < 0 ? -m : m;
  endfunction

  function automatic int rnd8();
    logic [7:0] b;
    b = 8'($urandom);
    return int'($signed(b));
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(int len, bit gaps, string tag);
    int sum;
    sum = vb[0];
    for (int i = 0; i < len; i++) sum += clampm(vx[i], vw[i]) + clampm(vx[i], vn[i]);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        in_valid = 0; in_last = 1'b1;
        in_x = 8'(rnd8()); in_w = 8'(rnd8()); in_n = 8'(rnd8()); in_bias = 8'(rnd8());
      end
      @(negedge clk);
      in_valid = 1; in_last = (i == len-1);
      in_x = 8'(vx[i]); in_w = 8'(vw[i]); in_n = 8'(vn[i]); in_bias = 8'(vb[i]);
    end
    exp_q.push_back(sum >>> SHIFT);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_last = 0;
    end
  endtask

  task automatic one(int x, int w, int n, int b, string tag);
    vx[0] = x; vw[0] = w; vn[0] = n; vb[0] = b;
    send(1, 0, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check("R8 unexpected out_valid", 1, 0);
        else check(tag_q.pop_front(), int'(out_y), exp_q.pop_front());
      end else begin
        check("R10 out_y hold", int'(out_y), last_y);
      end
      last_y = int'(out_y);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset out_valid", int'(out_valid), 0);
    check("R10 reset out_y", int'(out_y), 0);
    one(50, 20, 127, 0, "R1 channel clamp");
    one(-50, 127, -10, 0, "R2 leak clamp");
    one(-128, -128, 5, 0, "R5 most negative");
    one(0, -128, 127, 8, "R6 zero input");
    one(0, 0, 0, -1, "R4 negative shift");
    idle(2);
    for (int i = 0; i < DEPTH; i++) begin
      vx[i] = 0; vw[i] = 100; vn[i] = -100; vb[i] = (i == 0) ? 40 : 100;
    end
    send(DEPTH, 0, "R3 bias once");
    for (int i = 0; i < DEPTH; i++) begin
      vx[i] = -128; vw[i] = -128; vn[i] = -128; vb[i] = -128;
    end
    send(DEPTH, 0, "R7 full negative");
    for (int i = 0; i < DEPTH; i++) begin
      vx[i] = 127; vw[i] = 127; vn[i] = -128; vb[i] = 127;
    end
    send(DEPTH, 0, "R7 full positive");
    for (int v = 0; v < 60; v++) begin
      int len;
      len = 1 + int'($urandom % DEPTH);
      for (int i = 0; i < len; i++) begin
        vx[i] = rnd8(); vw[i] = rnd8(); vn[i] = rnd8(); vb[i] = rnd8();
      end
      if (v % 2 == 0) send(len, 0, "R9 back to back");
      else send(len, 1, "R11 gaps ignored");
    end
    idle(4);
    check("R8 all results seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule